// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is a small read-only cache that sits between a requester issuing 32-bit word reads and a slower backing memory. It holds eight 32-bit words arranged as two sets of two ways. Each way of each set holds one line of two words with its own tag and valid bit. A request is presented with a 12-bit byte address over a valid/ready handshake. Both ways of the addressed set are compared against the request tag in the same cycle. A match returns the word on the next cycle, flagged as a hit.

When neither way matches, the cache stops accepting requests. It asks the backing memory for the whole two-word line and takes the two words as a burst, lowest word first. It writes them into a victim way, then returns the requested word flagged as a miss. The victim is an invalid way when there is one, and otherwise the least recently used way of the set. One LRU bit per set tracks that way. Two free-running counters tally hits and misses.

Top module: `cache2w_top`

## Requirements
- R1: The byte address splits into tag = addr[11:4], set index = addr[3], word select = addr[2]. Bits [1:0] have no effect: the returned data is always the aligned 32-bit word.
- R2: After reset every line is invalid, req_ready is 1, resp_valid and mem_req are 0, and both counters read 0. The first access to any address is a miss.
- R3: On an accepted request whose tag matches a valid way of its set, resp_valid rises on the next cycle with resp_hit = 1 and that way's word. At most one way ever matches.
- R4: Two lines with the same set index and different tags can both be resident, so that alternating accesses to them both hit.
- R5: On a miss, mem_req goes high with mem_addr equal to the line base address (addr[11:3], low three bits zero). Two beats are taken on mem_rvalid, word 0 then word 1. In the cycle after the second beat, resp_valid rises with resp_hit = 0 and the requested word. The other word of the line then hits.
- R6: req_ready is 0 from the cycle after a miss is accepted until the fill completes, and mem_req is never high while req_ready is high.
- R7: The victim way is way 0 if it is invalid, else way 1 if it is invalid, else the least recently used way of the set.
- R8: Every hit and every fill marks the used way as most recently used in its set.
- R9: hit_count rises by one for every hit and miss_count by one for every miss. Both wrap at their width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 12 | Byte address of the read |
| req_ready | output | 1 | Cache can accept a request |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Response came from a hit (1) or a fill (0) |
| resp_data | output | 32 | Returned word |
| mem_req | output | 1 | Line fill request, held until the fill completes |
| mem_addr | output | 12 | Byte address of the line being filled |
| mem_rvalid | input | 1 | Fill beat valid |
| mem_rdata | input | 32 | Fill beat data |
| hit_count | output | 16 | Running hit total |
| miss_count | output | 16 | Running miss total |

## Verification
The bench builds the cache with its default geometry: 12-bit addresses, a 1-bit set index and a 1-bit word select, so there are only two sets of two ways. With only two sets, a handful of tags is enough to cause constant evictions. The directed sequences and the random traffic therefore reach every victim-choice case: invalid way 0, invalid way 1, and LRU eviction in both ways. Random traffic draws its tags from a pool of eight near tags plus a far group, and uses random byte offsets. A bench model of the two-way LRU organisation predicts every hit or miss, every returned word and both final counts.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
    localparam int WAYS = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } fill_st_e;
endpackage

// File: rtl/c2w_tag_lookup.sv
module c2w_tag_lookup #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 8
) (
    input  logic [WAYS-1:0]            way_vld,
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [TAG_W-1:0]           tag_in,
    output logic [WAYS-1:0]            way_hit,
    output logic                       hit,
    output logic                       hit_way
);
    // one comparator per way, all evaluated at once
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign way_hit[g] = way_vld[g] && (way_tag[g] == tag_in);
    end

    assign hit = |way_hit;

    always_comb begin
        hit_way = 1'b0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (way_hit[i]) hit_way = 1'(i);
        end
    end
endmodule

// File: rtl/c2w_victim_sel.sv
module c2w_victim_sel (
    input  logic [1:0] way_vld,
    input  logic       lru_way,
    output logic       victim
);
    always_comb begin
        if (!way_vld[0])      victim = 1'b0;
        else if (!way_vld[1]) victim = 1'b1;
        else                  victim = lru_way;
    end
endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
    import cache2w_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 1,
    parameter int WSEL_W = 1,
    parameter int OFF_W  = 2,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [DATA_W-1:0] resp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    localparam int SETS   = 1 << IDX_W;
    localparam int WORDS  = 1 << WSEL_W;
    localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - OFF_W;
    localparam int WADR_W = ADDR_W - OFF_W;
    localparam int LOW_W  = OFF_W + WSEL_W;

    typedef struct packed {
        fill_st_e                                       st;
        logic [WAYS-1:0][SETS-1:0]                      vld;
        logic [WAYS-1:0][SETS-1:0][TAG_W-1:0]           tag;
        logic [WAYS-1:0][SETS-1:0][WORDS-1:0][DATA_W-1:0] dat;
        logic [SETS-1:0]                                lru;
        logic [WADR_W-1:0]                              waddr;
        logic                                           victim;
        logic [WSEL_W-1:0]                              beat;
        logic                                           rsp_v;
        logic                                           rsp_hit;
        logic [DATA_W-1:0]                              rsp_dat;
        logic [CNT_W-1:0]                               hits;
        logic [CNT_W-1:0]                               misses;
    } state_t;

    state_t r_d, r_q;

    // request address fields
    logic [TAG_W-1:0]  tag_in;
    logic [IDX_W-1:0]  idx_in;
    logic [WSEL_W-1:0] wsel_in;
    logic              unused_offset;

    assign tag_in        = req_addr[ADDR_W-1 -: TAG_W];
    assign idx_in        = req_addr[LOW_W +: IDX_W];
    assign wsel_in       = req_addr[OFF_W +: WSEL_W];
    assign unused_offset = ^req_addr[OFF_W-1:0];

    // pending fill fields
    logic [TAG_W-1:0]  p_tag;
    logic [IDX_W-1:0]  p_idx;
    logic [WSEL_W-1:0] p_wsel;

    assign p_tag  = r_q.waddr[WADR_W-1 -: TAG_W];
    assign p_idx  = r_q.waddr[WSEL_W +: IDX_W];
    assign p_wsel = r_q.waddr[WSEL_W-1:0];

    // per-way view of the addressed set
    logic [WAYS-1:0]            set_vld;
    logic [WAYS-1:0][TAG_W-1:0] set_tag;

    for (genvar w = 0; w < WAYS; w++) begin : g_set
        assign set_vld[w] = r_q.vld[w][idx_in];
        assign set_tag[w] = r_q.tag[w][idx_in];
    end

    logic [WAYS-1:0] way_hit;
    logic            hit;
    logic            hit_way;
    logic            victim;

    c2w_tag_lookup #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W)
    ) u_lookup (
        .way_vld (set_vld),
        .way_tag (set_tag),
        .tag_in  (tag_in),
        .way_hit (way_hit),
        .hit     (hit),
        .hit_way (hit_way)
    );

    c2w_victim_sel u_victim (
        .way_vld (set_vld),
        .lru_way (r_q.lru[idx_in]),
        .victim  (victim)
    );

    always_comb begin
        r_d       = r_q;
        r_d.rsp_v = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (hit) begin
                        r_d.rsp_v       = 1'b1;
                        r_d.rsp_hit     = 1'b1;
                        r_d.rsp_dat     = r_q.dat[hit_way][idx_in][wsel_in];
                        r_d.lru[idx_in] = ~hit_way;
                        r_d.hits        = r_q.hits + 1'b1;
                    end else begin
                        r_d.st     = ST_FILL;
                        r_d.waddr  = req_addr[ADDR_W-1:OFF_W];
                        r_d.victim = victim;
                        r_d.beat   = '0;
                    end
                end
            end
            ST_FILL: begin
                if (mem_rvalid) begin
                    r_d.dat[r_q.victim][p_idx][r_q.beat] = mem_rdata;
                    if (r_q.beat == p_wsel) r_d.rsp_dat = mem_rdata;
                    r_d.beat = r_q.beat + 1'b1;
                    if (r_q.beat == WSEL_W'(WORDS - 1)) begin
                        r_d.vld[r_q.victim][p_idx] = 1'b1;
                        r_d.tag[r_q.victim][p_idx] = p_tag;
                        r_d.lru[p_idx]             = ~r_q.victim;
                        r_d.rsp_v                  = 1'b1;
                        r_d.rsp_hit                = 1'b0;
                        r_d.misses                 = r_q.misses + 1'b1;
                        r_d.st                     = ST_IDLE;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign req_ready  = (r_q.st == ST_IDLE);
    assign mem_req    = (r_q.st == ST_FILL);
    assign mem_addr   = {r_q.waddr[WADR_W-1:WSEL_W], LOW_W'(0)};
    assign resp_valid = r_q.rsp_v;
    assign resp_hit   = r_q.rsp_hit;
    assign resp_data  = r_q.rsp_dat;
    assign hit_count  = r_q.hits;
    assign miss_count = r_q.misses;
endmodule

// File: rtl/c2w_checker.sv
module c2w_checker #(
    parameter int WAYS  = 2,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             resp_valid,
    input logic             resp_hit,
    input logic             mem_req,
    input logic             mem_rvalid,
    input logic [WAYS-1:0]  way_hit,
    input logic [CNT_W-1:0] hit_count,
    input logic [CNT_W-1:0] miss_count
);
    // R3: never two ways claiming the same tag
    a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> $onehot0(way_hit));

    // R3: a hit is answered on the following cycle
    a_r3_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (|way_hit)) |=> (resp_valid && resp_hit));

    // R6: no new request taken while a fill is outstanding
    a_r6_ready_low_fill: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    // R5: a miss response follows a fill beat
    a_r5_miss_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> $past(mem_rvalid));

    // R9: hit counter steps on each hit
    a_r9_hit_count: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (|way_hit)) |=> (hit_count == CNT_W'($past(hit_count) + 1'b1)));

    // R9: miss counter untouched by a hit response
    a_r9_miss_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit) |-> $stable(miss_count));
endmodule

bind cache2w_top c2w_checker #(
    .WAYS  (cache2w_pkg::WAYS),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .mem_req    (mem_req),
    .mem_rvalid (mem_rvalid),
    .way_hit    (way_hit),
    .hit_count  (hit_count),
    .miss_count (miss_count)
);

// File: tb/tb_cache2w_top.sv
`timescale 1ns/1ps
module tb_cache2w_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [11:0] req_addr = '0;
    logic        req_ready, resp_valid, resp_hit, mem_req;
    logic [31:0] resp_data;
    logic [11:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [15:0] hit_count, miss_count;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    cache2w_top dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_data(resp_data), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    function automatic logic [31:0] mem_word(input logic [11:0] a);
        logic [31:0] w;
        w = {22'd0, a[11:2]};
        return 32'h5A3C_0000 ^ (w * 32'h0000_9E37) ^ {a[11:2], 22'd0};
    endfunction

    // backing memory: word 0 on the third cycle after the request, word 1 on the next
    int          mcnt = 0;
    bit          mbusy = 1'b0;
    logic [11:0] maddr = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            mbusy      <= 1'b0;
            mem_rvalid <= 1'b0;
        end else if (mbusy) begin
            mcnt       <= mcnt + 1;
            mem_rvalid <= (mcnt + 1 == 3) || (mcnt + 1 == 4);
            mem_rdata  <= mem_word(maddr + ((mcnt + 1 == 4) ? 12'd4 : 12'd0));
            if (mcnt + 1 == 4) mbusy <= 1'b0;
        end else if (mem_req) begin
            mbusy      <= 1'b1;
            mcnt       <= 0;
            maddr      <= mem_addr;
            mem_rvalid <= 1'b0;
        end else begin
            mem_rvalid <= 1'b0;
        end
    end

    // reference model of a 2-way, 2-set LRU cache
    bit       m_vld [2][2];
    bit [7:0] m_tag [2][2];
    bit       m_lru [2];
    int       exp_hits = 0;
    int       exp_misses = 0;

    task automatic model_step(input logic [11:0] a, output bit is_hit);
        int s;
        int v;
        s = int'(a[3]);
        is_hit = 1'b0;
        for (int w = 0; w < 2; w++) begin
            if (m_vld[w][s] && m_tag[w][s] == a[11:4]) begin
                is_hit   = 1'b1;
                m_lru[s] = (w == 0);
            end
        end
        if (is_hit) begin
            exp_hits++;
        end else begin
            if (!m_vld[0][s])      v = 0;
            else if (!m_vld[1][s]) v = 1;
            else                   v = int'(m_lru[s]);
            m_vld[v][s] = 1'b1;
            m_tag[v][s] = a[11:4];
            m_lru[s]    = (v == 0);
            exp_misses++;
        end
    endtask

    task automatic chk(input string rq, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
        end
    endtask

    task automatic do_access(input logic [11:0] a, input string rq);
        bit eh;
        int waitc;
        model_step(a, eh);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (!eh) begin
            chk("R6 ready low during fill", req_ready == 1'b0, 32'(req_ready), 32'd0);
            chk("R5 line base address", mem_req && mem_addr == {a[11:3], 3'b000},
                32'(mem_addr), 32'({a[11:3], 3'b000}));
        end
        waitc = 0;
        while (!resp_valid && waitc < 20) begin
            @(negedge clk);
            waitc++;
        end
        chk({rq, " response strobe"}, resp_valid == 1'b1, 32'(resp_valid), 32'd1);
        chk({rq, " hit flag"}, resp_hit == eh, 32'(resp_hit), 32'(eh));
        chk({rq, " R1 data"}, resp_data == mem_word({a[11:2], 2'b00}), resp_data,
            mem_word({a[11:2], 2'b00}));
        if (eh) chk("R3 hit latency", waitc == 0, 32'(waitc), 32'd0);
        else    chk("R5 fill latency", waitc == 5, 32'(waitc), 32'd5);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [11:0] seq [7];
        void'($urandom(32'd1234));
        seq = '{12'h010, 12'h1FC, 12'h168, 12'h008, 12'h014, 12'h1F8, 12'h00C};

        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        chk("R2 ready after reset", req_ready == 1'b1, 32'(req_ready), 32'd1);
        chk("R2 no response after reset", resp_valid == 1'b0, 32'(resp_valid), 32'd0);
        chk("R2 no fill after reset", mem_req == 1'b0, 32'(mem_req), 32'd0);
        chk("R2 hit_count zero", hit_count == 16'd0, 32'(hit_count), 32'd0);
        chk("R2 miss_count zero", miss_count == 16'd0, 32'(miss_count), 32'd0);

        // R4 R7 R8: two tags in set 0, then a third evicting the LRU one
        do_access(12'h000, "R2 first access");
        do_access(12'h100, "R7 second way filled");
        do_access(12'h000, "R4 first line still resident");
        do_access(12'h104, "R5 other word of line");
        do_access(12'h203, "R8 evicts LRU line 0x000");
        do_access(12'h100, "R8 MRU line kept");
        do_access(12'h002, "R8 evicted line misses");
        do_access(12'h208, "R1 set 1 independent");

        // pattern from a classic hit-rate exercise, four passes
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 7; k++) do_access(seq[k], "R4 pattern");
        end

        // constrained random traffic with random byte offsets
        for (int i = 0; i < 400; i++) begin
            logic [11:0] a;
            a[11:7] = ($urandom % 4 == 0) ? 5'h1F : 5'h00;
            a[6:4]  = 3'($urandom % 8);
            a[3:0]  = 4'($urandom);
            do_access(a, "R3/R5 random");
        end

        @(negedge clk);
        chk("R9 hit_count", hit_count == 16'(exp_hits), 32'(hit_count), 32'(exp_hits));
        chk("R9 miss_count", miss_count == 16'(exp_misses), 32'(miss_count), 32'(exp_misses));
        chk("R6 ready when idle", req_ready == 1'b1, 32'(req_ready), 32'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule